// File: doc/BRIEF.md
# Cache Inquire Snoop Responder

This block answers inquire cycles that an external bus agent starts in order to find out whether a cache holds a given line. The agent drives an address together with a one-clock inquire strobe. The block captures the address and reads one entry from an instruction-cache tag array and one from a data-cache tag array. It then reports two results at a fixed latency. The first says the line is present in either cache. The second says the data cache holds the line in the modified state.

A modified hit must be written back before anything else happens. The block raises a write-back request and keeps both hit results asserted until the write-back acknowledge arrives. At that point it marks the data-cache line clean. An invalidate flag captured with the inquire address then decides whether the line also loses its valid bit. Inquire strobes that arrive while a write-back is pending are not accepted.

Both tag arrays are direct-mapped with 16 entries, written so that block RAM can hold them. They are filled through a load port used by test and by the surrounding cache logic. The bus cycle that moves the written-back data belongs to other logic.

Top module: `snoop_responder`

## Requirements
- R1: After a synchronous reset, `hit_o`, `hitm_o` and `wb_req_o` are all low.
- R2: An accepted inquire drives `hit_o` high when its tag equals the stored tag of a valid entry at its index in the instruction array or in the data array.
- R3: `hitm_o` goes high only when the data-array entry at the inquire index is valid, dirty and holds the inquire tag. `hitm_o` high always comes with `hit_o` high.
- R4: The results of an inquire whose strobe is sampled at rising edge E0 appear after rising edge E1 and are sampled at E2. After E0 alone, both hit outputs are still low.
- R5: On a modified hit, `wb_req_o` rises together with `hitm_o`. `hit_o`, `hitm_o` and `wb_req_o` stay high until `wb_ack_i` is sampled high, and all three are low after that edge.
- R6: A completed write-back leaves the data entry with the dirty bit clear. The valid bit is cleared if `inval_i` was high with the inquire strobe and is kept otherwise. A later inquire to the same address shows this.
- R7: A strobe is ignored, with no result produced for it, in two cases: a write-back is pending, or the strobe comes in the cycle right after an accepted strobe.
- R8: A result that is not a modified hit lasts exactly one cycle. Outside a result window both hit outputs are low.
- R9: Address bits [3:0] are a line offset and take no part in the lookup. Bits [7:4] select the entry and bits [15:8] form the tag.
- R10: A load writes the entry `ld_idx_i` of the instruction array when `ld_sel_i`=0, or of the data array when `ld_sel_i`=1, with `ld_valid_i`, `ld_tag_i`, and, for the data array only, `ld_dirty_i`.
- R11: `wb_ack_i` has no effect while no write-back is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inq_stb_i | input | 1 | Inquire strobe, one clock per inquire |
| inq_addr_i | input | 16 | Inquire address |
| inval_i | input | 1 | Invalidate the line after write-back, sampled with the strobe |
| hit_o | output | 1 | Line present in either cache |
| hitm_o | output | 1 | Line present and modified in the data cache |
| wb_req_o | output | 1 | Write-back request for the modified line |
| wb_ack_i | input | 1 | Write-back complete |
| ld_en_i | input | 1 | Tag load enable |
| ld_sel_i | input | 1 | Load target: 0 instruction array, 1 data array |
| ld_idx_i | input | 4 | Entry to load |
| ld_tag_i | input | 8 | Tag to store |
| ld_valid_i | input | 1 | Valid bit to store |
| ld_dirty_i | input | 1 | Dirty bit to store (data array) |

## Verification
The bench fills both arrays with an arithmetic pattern. For every index it then sweeps three tags: the instruction tag, the data tag, and a tag held by neither array. The offset bits vary on every inquire, so a design that folds offset bits into the index or the tag reports the wrong line. The outputs are sampled one edge early and one edge late as well as at E2. A result that came a cycle early, or a hit that stayed up past its window, would therefore be caught. Each modified hit is held for a varying wait. A strobe is injected during the wait and a stray acknowledge is sent beforehand. The line is then queried again after its write-back. A responder that drops the hold early, accepts a blocked strobe, fails to clear the dirty bit, or mishandles the invalidate flag gives a wrong result on one of these steps.

// File: rtl/snoop_pkg.sv
package snoop_pkg;
  typedef enum logic {
    SEL_INSTR = 1'b0,
    SEL_DATA  = 1'b1
  } cache_sel_e;
endpackage

// File: rtl/snoop_tag_ram.sv
module snoop_tag_ram #(
  parameter int WIDTH = 10,
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // registered read, read-before-write on collision
  always_ff @(posedge clk) begin
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/snoop_tag_match.sv
module snoop_tag_match #(
  parameter int TAG_W = 8
) (
  input  logic [TAG_W:0]   i_entry,   // {valid, tag}
  input  logic [TAG_W+1:0] d_entry,   // {valid, dirty, tag}
  input  logic [TAG_W-1:0] tag,
  output logic             hit,
  output logic             hitm
);
  logic i_match, d_match;

  always_comb begin
    i_match = i_entry[TAG_W] && (i_entry[TAG_W-1:0] == tag);
    d_match = d_entry[TAG_W+1] && (d_entry[TAG_W-1:0] == tag);
    hit     = i_match || d_match;
    hitm    = d_match && d_entry[TAG_W];
  end
endmodule

// File: rtl/snoop_responder.sv
module snoop_responder #(
  parameter int ADDR_W = 16,
  parameter int OFS_W  = 4,
  parameter int IDX_W  = 4,
  localparam int TAG_W = ADDR_W - IDX_W - OFS_W,
  localparam int DEPTH = 1 << IDX_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inq_stb_i,
  input  logic [ADDR_W-1:0] inq_addr_i,
  input  logic              inval_i,
  output logic              hit_o,
  output logic              hitm_o,
  output logic              wb_req_o,
  input  logic              wb_ack_i,
  input  logic              ld_en_i,
  input  logic              ld_sel_i,
  input  logic [IDX_W-1:0]  ld_idx_i,
  input  logic [TAG_W-1:0]  ld_tag_i,
  input  logic              ld_valid_i,
  input  logic              ld_dirty_i
);
  import snoop_pkg::*;

  localparam int IW = TAG_W + 1;
  localparam int DW = TAG_W + 2;

  logic [IDX_W-1:0] rd_idx;
  logic [TAG_W-1:0] in_tag;
  logic             accept, wb_done;
  logic             s1_v;
  logic [IDX_W-1:0] cap_idx;
  logic [TAG_W-1:0] cap_tag;
  logic             cap_inval;

  logic             i_we, d_we;
  logic [IDX_W-1:0] d_waddr;
  logic [IW-1:0]    i_wdata, i_rdata;
  logic [DW-1:0]    d_wdata, d_rdata;
  logic             m_hit, m_hitm;

  assign rd_idx  = inq_addr_i[OFS_W +: IDX_W];
  assign in_tag  = inq_addr_i[OFS_W+IDX_W +: TAG_W];
  assign accept  = inq_stb_i && !s1_v && !wb_req_o;
  assign wb_done = wb_req_o && wb_ack_i;

  // write ports: write-back clean-up wins over a test load on the data array
  always_comb begin
    i_we    = ld_en_i && (cache_sel_e'(ld_sel_i) == SEL_INSTR);
    i_wdata = {ld_valid_i, ld_tag_i};
    d_we    = wb_done || (ld_en_i && (cache_sel_e'(ld_sel_i) == SEL_DATA));
    if (wb_done) begin
      d_waddr = cap_idx;
      d_wdata = {!cap_inval, 1'b0, cap_tag};
    end else begin
      d_waddr = ld_idx_i;
      d_wdata = {ld_valid_i, ld_dirty_i, ld_tag_i};
    end
  end

  snoop_tag_ram #(.WIDTH(IW), .DEPTH(DEPTH)) u_itag (
    .clk(clk), .we(i_we), .waddr(ld_idx_i), .wdata(i_wdata),
    .raddr(rd_idx), .rdata(i_rdata)
  );

  snoop_tag_ram #(.WIDTH(DW), .DEPTH(DEPTH)) u_dtag (
    .clk(clk), .we(d_we), .waddr(d_waddr), .wdata(d_wdata),
    .raddr(rd_idx), .rdata(d_rdata)
  );

  snoop_tag_match #(.TAG_W(TAG_W)) u_match (
    .i_entry(i_rdata), .d_entry(d_rdata), .tag(cap_tag),
    .hit(m_hit), .hitm(m_hitm)
  );

  // stage 1: capture the inquire while the arrays are read
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v      <= 1'b0;
      cap_idx   <= '0;
      cap_tag   <= '0;
      cap_inval <= 1'b0;
    end else begin
      s1_v <= accept;
      if (accept) begin
        cap_idx   <= rd_idx;
        cap_tag   <= in_tag;
        cap_inval <= inval_i;
      end
    end
  end

  // stage 2: registered results, held across a pending write-back
  always_ff @(posedge clk) begin
    if (rst) begin
      hit_o    <= 1'b0;
      hitm_o   <= 1'b0;
      wb_req_o <= 1'b0;
    end else if (wb_done) begin
      hit_o    <= 1'b0;
      hitm_o   <= 1'b0;
      wb_req_o <= 1'b0;
    end else if (s1_v) begin
      hit_o    <= m_hit;
      hitm_o   <= m_hitm;
      wb_req_o <= m_hitm;
    end else if (!wb_req_o) begin
      hit_o    <= 1'b0;
      hitm_o   <= 1'b0;
    end
  end

  // R3: a modified hit is always also a hit
  a_r3_hitm_has_hit: assert property (@(posedge clk) disable iff (rst)
    hitm_o |-> hit_o);

  // R4: a result only rises one edge after a captured inquire
  a_r4_latency: assert property (@(posedge clk) disable iff (rst)
    $rose(hit_o) |-> $past(s1_v));

  // R5: request and indication held until acknowledge
  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    (wb_req_o && !wb_ack_i) |=> (wb_req_o && hitm_o && hit_o));

  // R5: acknowledge releases everything
  a_r5_release: assert property (@(posedge clk) disable iff (rst)
    (wb_req_o && wb_ack_i) |=> (!wb_req_o && !hitm_o && !hit_o));

  // R7: a strobe during a pending write-back leaves the captured address alone
  a_r7_blocked: assert property (@(posedge clk) disable iff (rst)
    (wb_req_o && inq_stb_i) |=> ($stable(cap_tag) && $stable(cap_idx) && !s1_v));

  // R8: a plain hit lasts one cycle
  a_r8_one_cycle: assert property (@(posedge clk) disable iff (rst)
    (hit_o && !hitm_o) |=> !hit_o);

  // R11: acknowledge without request does nothing
  a_r11_stray_ack: assert property (@(posedge clk) disable iff (rst)
    (!wb_req_o && !s1_v && wb_ack_i) |=> (!wb_req_o && !hit_o));
endmodule

// File: tb/snoop_responder_test.sv
module snoop_responder_test;
  logic        clk = 1'b0;
  logic        rst;
  logic        inq_stb_i, inval_i, wb_ack_i;
  logic [15:0] inq_addr_i;
  logic        hit_o, hitm_o, wb_req_o;
  logic        ld_en_i, ld_sel_i, ld_valid_i, ld_dirty_i;
  logic [3:0]  ld_idx_i;
  logic [7:0]  ld_tag_i;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  // model arrays
  bit       iv [16];
  bit [7:0] it [16];
  bit       dv [16];
  bit       dd [16];
  bit [7:0] dt [16];

  always #10 clk = ~clk;

  snoop_responder uut (
    .clk(clk), .rst(rst), .inq_stb_i(inq_stb_i), .inq_addr_i(inq_addr_i),
    .inval_i(inval_i), .hit_o(hit_o), .hitm_o(hitm_o), .wb_req_o(wb_req_o),
    .wb_ack_i(wb_ack_i), .ld_en_i(ld_en_i), .ld_sel_i(ld_sel_i),
    .ld_idx_i(ld_idx_i), .ld_tag_i(ld_tag_i), .ld_valid_i(ld_valid_i),
    .ld_dirty_i(ld_dirty_i)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_outs(input string req, input bit eh, input bit em, input bit er);
    chk(hit_o == eh, {req, " hit_o"}, hit_o, eh);
    chk(hitm_o == em, {req, " hitm_o"}, hitm_o, em);
    chk(wb_req_o == er, {req, " wb_req_o"}, wb_req_o, er);
  endtask

  task automatic load(input bit sel, input int idx, input bit v, input bit d, input bit [7:0] tg);
    @(negedge clk);
    ld_en_i = 1'b1; ld_sel_i = sel; ld_idx_i = 4'(idx);
    ld_valid_i = v; ld_dirty_i = d; ld_tag_i = tg;
    @(negedge clk);
    ld_en_i = 1'b0;
  endtask

  // wait W cycles with the write-back pending, inject a blocked strobe, then acknowledge
  task automatic finish_wb(input int idx, input int w, input bit inv, input bit [7:0] other_tag);
    @(negedge clk);
    inq_stb_i = 1'b1; inq_addr_i = {other_tag, 4'(idx), 4'h3}; inval_i = 1'b0;
    @(negedge clk);
    inq_stb_i = 1'b0;
    chk_outs("R5 held", 1, 1, 1);
    for (int j = 0; j < w; j++) begin
      @(negedge clk);
      chk_outs("R5 held", 1, 1, 1);
    end
    wb_ack_i = 1'b1;
    @(negedge clk);
    wb_ack_i = 1'b0;
    chk_outs("R5 released", 0, 0, 0);
    @(negedge clk);
    chk_outs("R7 blocked strobe", 0, 0, 0);
    @(negedge clk);
    chk_outs("R7 blocked strobe", 0, 0, 0);
    dd[idx] = 1'b0;
    if (inv) dv[idx] = 1'b0;
  endtask

  task automatic inquire(input int idx, input bit [7:0] tg, input bit inv, input int w);
    bit eh, em;
    eh = (iv[idx] && it[idx] == tg) || (dv[idx] && dt[idx] == tg);
    em = dv[idx] && dd[idx] && dt[idx] == tg;
    @(negedge clk);
    inq_stb_i = 1'b1; inval_i = inv;
    inq_addr_i = {tg, 4'(idx), 4'((idx * 5 + tg) & 15)};   // R9 offset varies
    @(negedge clk);
    inq_stb_i = 1'b0; inval_i = 1'b0;
    chk_outs("R4 before latency", 0, 0, 0);
    @(negedge clk);
    chk_outs("R2 R3 R9 result", eh, em, em);
    if (em) begin
      finish_wb(idx, w, inv, tg ^ 8'hC3);
    end else begin
      @(negedge clk);
      chk_outs("R8 window closed", 0, 0, 0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog R5 act=0 exp=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; inq_stb_i = 1'b0; inq_addr_i = '0; inval_i = 1'b0; wb_ack_i = 1'b0;
    ld_en_i = 1'b0; ld_sel_i = 1'b0; ld_idx_i = '0; ld_tag_i = '0;
    ld_valid_i = 1'b0; ld_dirty_i = 1'b0;
    repeat (3) @(negedge clk);
    chk_outs("R1 reset", 0, 0, 0);
    rst = 1'b0;

    // R10: fill both arrays with an arithmetic pattern
    for (int i = 0; i < 16; i++) begin
      iv[i] = (i % 3) != 0;
      it[i] = 8'(i * 7 + 1);
      dv[i] = (i % 2) == 0 || i == 5;
      dd[i] = (i % 4) == 0 || i == 5;
      dt[i] = (i % 5 == 0) ? it[i] : 8'(i * 11 + 3);
      load(1'b0, i, iv[i], 1'b1, it[i]);   // dirty bit ignored for instruction array
      load(1'b1, i, dv[i], dd[i], dt[i]);
    end
    chk_outs("R1 idle after loads", 0, 0, 0);

    // R11: stray acknowledge, then a dirty line still reports modified
    @(negedge clk); wb_ack_i = 1'b1;
    @(negedge clk); wb_ack_i = 1'b0;
    chk_outs("R11 stray ack", 0, 0, 0);
    inquire(0, dt[0], 1'b0, 1);
    inquire(0, dt[0], 1'b0, 0);            // R6 clean, still valid: plain hit

    // R7: back-to-back strobe, the second one is ignored
    @(negedge clk);
    inq_stb_i = 1'b1; inq_addr_i = {it[1], 4'd1, 4'h0};
    @(negedge clk);
    inq_addr_i = {it[2], 4'd2, 4'h0};
    @(negedge clk);
    inq_stb_i = 1'b0;
    chk_outs("R7 first result", 1, 0, 0);
    @(negedge clk);
    chk_outs("R7 second ignored", 0, 0, 0);
    @(negedge clk);
    chk_outs("R7 second ignored", 0, 0, 0);

    // main sweep over every index and three tags (R2 R3 R6 R9)
    for (int i = 0; i < 16; i++) begin
      for (int k = 0; k < 3; k++) begin
        bit [7:0] tg;
        tg = (k == 0) ? it[i] : (k == 1) ? dt[i] : (it[i] ^ dt[i] ^ 8'h5A);
        inquire(i, tg, i[0], i % 3);
      end
      inquire(i, dt[i], 1'b0, 0);          // R6 post write-back view
    end

    // R10 reload makes a line dirty again
    load(1'b1, 8, 1'b1, 1'b1, 8'hE7);
    dv[8] = 1'b1; dd[8] = 1'b1; dt[8] = 8'hE7;
    inquire(8, 8'hE7, 1'b1, 2);
    inquire(8, 8'hE7, 1'b0, 0);            // R6 invalidated: no hit from data array

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule